// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is one direction of a two-clock first-in first-out buffer. A producer writes 18-bit words on its own clock, and a consumer reads them on a second, unrelated clock. The storage holds DEPTH words, where DEPTH is 256 or 512. Four active-low status flags report the fill level. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. Each side therefore sees its flags in its own timing.

The two pointers are one bit wider than the address and cross between the domains as Gray code through two-flop synchronizers. The almost-empty and almost-full thresholds are loaded at run time through a small write-clock configuration strobe, and both reset to 8. The offset registers drive the read domain as quasi-static values, so they are meant to be loaded while the buffer is idle.

Top module: `xfifo_pflag`

## Requirements
- R1: While `rst` is high on a clock edge, that domain's state clears: `empty_n`=0 and `aempty_n`=0 on the read side, `full_n`=1 and `afull_n`=1 on the write side, both pointers at the first location, and both threshold offsets equal to 8.
- R2: A word is stored on a `clk_w` rising edge only when `wr_en_n`=0 and `wr_dir`=0. A word is read on a `clk_r` rising edge only when `rd_en_n`=0 and `rd_dir`=1. Any other combination leaves the contents, the flags and `rd_data` unchanged.
- R3: `full_n` is 0 exactly when DEPTH words are stored. While it is 0, write requests are ignored and the stored words stay intact.
- R4: `empty_n` is 0 exactly when no word is stored. While it is 0, read requests are ignored and `rd_data` keeps its last value.
- R5: `aempty_n` is 0 when the occupancy is at most N, the almost-empty offset, and 1 when it is above N.
- R6: `afull_n` is 0 when the occupancy is at least DEPTH−M, where M is the almost-full offset, and 1 when it is at most DEPTH−M−1.
- R7: A `clk_w` edge with `cfg_we`=1 loads `cfg_val` into N when `cfg_sel`=0, or into M when `cfg_sel`=1.
- R8: When DEPTH is 256, bit 8 of `cfg_val` is ignored and treated as zero. For example, a value of 0x114 behaves as 20.
- R9: Words leave in the order they entered. `rd_data` changes on the read edge that performs a read and holds otherwise.
- R10: After a word is written into an empty buffer, `empty_n` rises on the second to fourth `clk_r` rising edge after the write edge. The exact edge depends on where the two clocks' edges fall relative to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst | input | 1 | Active-high synchronous reset, held across edges of both clocks |
| wr_en_n | input | 1 | Write-side enable, active low |
| wr_dir | input | 1 | Write-side direction; 0 selects a write |
| wr_data | input | 18 | Word to store |
| rd_en_n | input | 1 | Read-side enable, active low |
| rd_dir | input | 1 | Read-side direction; 1 selects a read |
| rd_data | output | 18 | Registered read word |
| cfg_we | input | 1 | Offset load strobe, on `clk_w` |
| cfg_sel | input | 1 | 0 selects the almost-empty offset, 1 the almost-full offset |
| cfg_val | input | 9 | Offset value to load |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| aempty_n | output | 1 | Low when occupancy ≤ N (read domain) |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| afull_n | output | 1 | Low when occupancy ≥ DEPTH−M (write domain) |

## Verification
The write into storage and the read out of it can land in the same stretch of cycles while the buffer sits at its full boundary. In that situation the full flag must release only after the read pointer has crossed over, and the data order must survive. The bench provokes this by pre-filling to near capacity. It then runs a free-running writer on the faster clock against a reader on the slower one, with each side gating itself only on its own flag. Every word that comes out is compared against a queue of the words accepted, so a lost, duplicated or overwritten word shows up as a data mismatch.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int unsigned PTR_MAX = 16;

  typedef enum logic {
    OFS_AEMPTY = 1'b0,
    OFS_AFULL  = 1'b1
  } ofs_sel_e;

  function automatic logic [PTR_MAX-1:0] to_gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] from_gray(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xf_sync.sv
module xf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xf_ram.sv
module xf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xf_ofs_regs.sv
module xf_ofs_regs
  import xf_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [OW-1:0] cfg_val,
  output logic [OW-1:0] ae_ofs,
  output logic [OW-1:0] af_ofs
);
  logic [OW-1:0] val_m;

  generate
    if (AW < OW) begin : g_trim
      assign val_m = OW'(cfg_val[AW-1:0]);
    end else begin : g_full
      assign val_m = cfg_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ae_ofs <= OW'(8);
      af_ofs <= OW'(8);
    end else if (cfg_we) begin
      if (cfg_sel == OFS_AFULL) af_ofs <= val_m;
      else                      ae_ofs <= val_m;
    end
  end
endmodule

// File: rtl/xf_wr_ctl.sv
module xf_wr_ctl
  import xf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9,
  parameter int OW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          wr_dir,
  input  logic [PW-1:0] rgray_s,
  input  logic [OW-1:0] af_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n
);
  localparam logic [PW:0] DEPTH_W = (PW+1)'(DEPTH);

  logic [PW-1:0]      wbin, wbin_nx, rbin_s, occ_nx;
  logic [PTR_MAX-1:0] g_wide, b_wide;
  logic [PW:0]        af_lim;

  assign we      = ~wr_en_n & ~wr_dir & full_n;
  assign wbin_nx = wbin + PW'(we);
  assign g_wide  = to_gray(PTR_MAX'(wbin_nx));
  assign b_wide  = from_gray(PTR_MAX'(rgray_s));
  assign rbin_s  = b_wide[PW-1:0];
  assign occ_nx  = wbin_nx - rbin_s;
  assign af_lim  = DEPTH_W - (PW+1)'(af_ofs);
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= g_wide[PW-1:0];
      full_n  <= ({1'b0, occ_nx} != DEPTH_W);
      afull_n <= ({1'b0, occ_nx} < af_lim);
    end
  end
endmodule

// File: rtl/xf_rd_ctl.sv
module xf_rd_ctl
  import xf_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 9,
  parameter int OW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_n,
  input  logic          rd_dir,
  input  logic [PW-1:0] wgray_s,
  input  logic [OW-1:0] ae_ofs,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [PW-1:0]      rbin, rbin_nx, wbin_s, occ_nx;
  logic [PTR_MAX-1:0] g_wide, b_wide;

  assign re      = ~rd_en_n & rd_dir & empty_n;
  assign rbin_nx = rbin + PW'(re);
  assign g_wide  = to_gray(PTR_MAX'(rbin_nx));
  assign b_wide  = from_gray(PTR_MAX'(wgray_s));
  assign wbin_s  = b_wide[PW-1:0];
  assign occ_nx  = wbin_s - rbin_nx;
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= g_wide[PW-1:0];
      empty_n  <= (occ_nx != '0);
      aempty_n <= ({1'b0, occ_nx} > (PW+1)'(ae_ofs));
    end
  end
endmodule

// File: rtl/xfifo_pflag.sv
module xfifo_pflag #(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  parameter int OW    = 9
) (
  input  logic          clk_w,
  input  logic          clk_r,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          wr_dir,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          rd_dir,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [OW-1:0] cfg_val,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [OW-1:0] ae_ofs, af_ofs;

  xf_ofs_regs #(.AW(AW), .OW(OW)) u_ofs (
    .clk(clk_w), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  xf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OW(OW)) u_wr (
    .clk(clk_w), .rst(rst), .wr_en_n(wr_en_n), .wr_dir(wr_dir),
    .rgray_s(rgray_s), .af_ofs(af_ofs), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n)
  );

  xf_rd_ctl #(.AW(AW), .PW(PW), .OW(OW)) u_rd (
    .clk(clk_r), .rst(rst), .rd_en_n(rd_en_n), .rd_dir(rd_dir),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .re(re), .raddr(raddr),
    .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  xf_sync #(.W(PW)) u_w2r (.clk(clk_r), .rst(rst), .d(wgray), .q(wgray_s));
  xf_sync #(.W(PW)) u_r2w (.clk(clk_w), .rst(rst), .d(rgray), .q(rgray_s));

  xf_ram #(.DW(DW), .AW(AW)) u_mem (
    .wclk(clk_w), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(clk_r), .rrst(rst), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/xfifo_pflag_chk.sv
module xfifo_pflag_chk #(
  parameter int PW = 9,
  parameter int DW = 18
) (
  input logic          clk_w,
  input logic          clk_r,
  input logic          rst,
  input logic          wr_en_n,
  input logic          wr_dir,
  input logic          rd_en_n,
  input logic          rd_dir,
  input logic [DW-1:0] rd_data,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          full_n,
  input logic          afull_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  p_reset_rd_r1: assert property (@(posedge clk_r) rst |=> (!empty_n && !aempty_n));
  p_reset_wr_r1: assert property (@(posedge clk_w) rst |=> (full_n && afull_n));

  p_gray_step_r2: assert property (@(posedge clk_w) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_no_overflow_r3: assert property (@(posedge clk_w) disable iff (rst)
    (!full_n && !wr_en_n && !wr_dir) |=> $stable(wgray));

  p_no_underflow_r4: assert property (@(posedge clk_r) disable iff (rst)
    !empty_n |=> ($stable(rd_data) && $stable(rgray)));

  p_empty_in_ae_r5: assert property (@(posedge clk_r) disable iff (rst)
    !empty_n |-> !aempty_n);

  p_full_in_af_r6: assert property (@(posedge clk_w) disable iff (rst)
    !full_n |-> !afull_n);

  p_hold_r9: assert property (@(posedge clk_r) disable iff (rst)
    (rd_en_n || !rd_dir) |=> $stable(rd_data));
endmodule

bind xfifo_pflag xfifo_pflag_chk #(.PW(PW), .DW(DW)) u_chk (
  .clk_w(clk_w), .clk_r(clk_r), .rst(rst), .wr_en_n(wr_en_n),
  .wr_dir(wr_dir), .rd_en_n(rd_en_n), .rd_dir(rd_dir), .rd_data(rd_data),
  .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
  .afull_n(afull_n), .wgray(wgray), .rgray(rgray)
);

// File: tb/xfifo_pflag_tb.sv
module xfifo_pflag_tb;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH = 256;

  logic clk_w = 1'b0, clk_r = 1'b0, rst = 1'b1;
  logic wr_en_n = 1'b1, wr_dir = 1'b0, rd_en_n = 1'b1, rd_dir = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [8:0] cfg_val = '0;
  logic empty_n, aempty_n, full_n, afull_n;

  int total = 0, bad = 0;
  int nofs = 8, mofs = 8;
  logic [17:0] q[$];
  logic [17:0] last_rd = '0;

  xfifo_pflag #(.DEPTH(DEPTH)) u_dut (
    .clk_w(clk_w), .clk_r(clk_r), .rst(rst), .wr_en_n(wr_en_n),
    .wr_dir(wr_dir), .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_dir(rd_dir),
    .rd_data(rd_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  always #(WCLK_PERIOD/2) clk_w = ~clk_w;
  initial begin
    #3;
    forever #(RCLK_PERIOD/2) clk_r = ~clk_r;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_r);
    repeat (5) @(negedge clk_w);
  endtask

  task automatic check_flags(input string tag);
    int occ;
    occ = q.size();
    chk({tag, " R4 empty_n"},  32'(empty_n),  32'(occ != 0));
    chk({tag, " R5 aempty_n"}, 32'(aempty_n), 32'(occ > nofs));
    chk({tag, " R3 full_n"},   32'(full_n),   32'(occ != DEPTH));
    chk({tag, " R6 afull_n"},  32'(afull_n),  32'(occ < DEPTH - mofs));
  endtask

  task automatic wr_word(input logic [17:0] d);
    @(negedge clk_w);
    wr_en_n = 1'b0; wr_dir = 1'b0; wr_data = d;
    @(negedge clk_w);
    wr_en_n = 1'b1;
    if (q.size() < DEPTH) q.push_back(d);
  endtask

  task automatic rd_word(input string tag);
    logic [17:0] e;
    @(negedge clk_r);
    rd_en_n = 1'b0; rd_dir = 1'b1;
    @(negedge clk_r);
    rd_en_n = 1'b1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({tag, " R9 data order"}, 32'(rd_data), 32'(e));
      last_rd = e;
    end else begin
      chk({tag, " R4 hold on empty read"}, 32'(rd_data), 32'(last_rd));
    end
  endtask

  task automatic load_ofs(input logic sel, input logic [8:0] v);
    @(negedge clk_w);
    cfg_we = 1'b1; cfg_sel = sel; cfg_val = v;
    @(negedge clk_w);
    cfg_we = 1'b0;
  endtask

  task automatic sweep(input string tag, input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(18'((i * 37 + seed) & 18'h3ffff));
      settle();
      check_flags({tag, " fill"});
    end
    wr_word(18'h2abcd);
    settle();
    check_flags({tag, " R3 write at full ignored"});
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(tag);
      settle();
      check_flags({tag, " drain"});
    end
  endtask

  initial begin
    #(1_500_000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int issued, wsent;
    bit pending;
    logic [17:0] e;

    repeat (4) @(negedge clk_r);
    rst = 1'b0;
    repeat (2) @(negedge clk_w);
    check_flags("R1 reset");

    // R2: wrong direction or disabled enable stores nothing
    @(negedge clk_w); wr_en_n = 1'b0; wr_dir = 1'b1; wr_data = 18'h11111;
    @(negedge clk_w); wr_en_n = 1'b1; wr_dir = 1'b0;
    settle();
    chk("R2 write with dir=1 ignored", 32'(empty_n), 32'd0);

    // R10: empty flag latency after first word
    @(negedge clk_w); wr_en_n = 1'b0; wr_dir = 1'b0; wr_data = 18'h00abc;
    @(posedge clk_w); #1 wr_en_n = 1'b1;
    q.push_back(18'h00abc);
    n = 0;
    while (!empty_n && n < 8) begin
      @(posedge clk_r); #1;
      n++;
    end
    chk("R10 empty_n rise not before edge 2", 32'(n >= 2), 32'd1);
    chk("R10 empty_n rise by edge 4", 32'(n <= 4), 32'd1);
    settle();

    // R2: read with dir=0 ignored
    @(negedge clk_r); rd_en_n = 1'b0; rd_dir = 1'b0;
    @(negedge clk_r); rd_en_n = 1'b1;
    chk("R2 read with dir=0 keeps rd_data", 32'(rd_data), 32'd0);
    settle();
    check_flags("R2 read with dir=0 keeps word");
    rd_word("R2 single");
    settle();
    rd_word("R4 empty read");
    settle();
    check_flags("R4 after empty read");

    // Full sweep with reset offsets (R1 offsets of 8)
    sweep("R1 default offsets", 5);

    // R7 and R8: load offsets; 0x114 acts as 20 at depth 256
    load_ofs(1'b0, 9'h114);
    load_ofs(1'b1, 9'd30);
    nofs = 20; mofs = 30;
    settle();
    check_flags("R7 after offset load");
    sweep("R7 R8 loaded offsets", 91);

    // Edge offsets: zero thresholds
    load_ofs(1'b0, 9'd0);
    load_ofs(1'b1, 9'd0);
    nofs = 0; mofs = 0;
    settle();
    check_flags("R5 R6 zero offsets empty");
    wr_word(18'h00001);
    settle();
    check_flags("R5 R6 zero offsets one word");
    rd_word("R9 zero offsets");
    settle();

    // Concurrent stream across the full boundary
    for (int i = 0; i < DEPTH - 6; i++) wr_word(18'(i + 1000));
    settle();
    check_flags("R6 prefill");
    issued = 0; wsent = 0; pending = 0;
    fork
      begin
        while (wsent < 300) begin
          @(negedge clk_w);
          if (full_n) begin
            wr_en_n = 1'b0; wr_dir = 1'b0; wr_data = 18'(wsent + 5000);
            q.push_back(18'(wsent + 5000));
            wsent++;
          end else begin
            wr_en_n = 1'b1;
          end
        end
        @(negedge clk_w);
        wr_en_n = 1'b1;
      end
      begin
        while (issued < DEPTH - 6 + 300 || pending) begin
          @(negedge clk_r);
          if (pending) begin
            e = q.pop_front();
            chk("R9 R3 concurrent order", 32'(rd_data), 32'(e));
          end
          if (issued < DEPTH - 6 + 300 && empty_n) begin
            rd_en_n = 1'b0; rd_dir = 1'b1;
            pending = 1'b1;
            issued++;
          end else begin
            rd_en_n = 1'b1;
            pending = 1'b0;
          end
        end
      end
    join
    settle();
    check_flags("R4 after stream");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule